// File: doc/BRIEF.md
# Retriggerable Resettable One-Shot Pulse Generator

This block is a clocked, counter-based one-shot. It watches two asynchronous trigger lines. One line fires on its rising edge and the other fires on its falling edge. Each line is accepted only when the other line sits at its enabling level. An accepted trigger raises the pulse output and lowers its complement for a fixed number of clock cycles, set by a parameter. A further accepted trigger during the pulse restarts the count, so the pulse lasts the full width after the last trigger.

An active-low clear line cuts a running pulse short. While the clear line is held low, every trigger edge is discarded. All three input lines pass through two-flop synchronisers before any edge is judged. The output therefore follows an input edge after a fixed latency of three clock edges, whatever width is configured.

Top module: `retrig_oneshot`

## Requirements
- R1: After synchronous reset, and with no accepted trigger, `pulse_o` is 0 and `pulse_n_o` is 1.
- R2: A 0-to-1 change on `rise_trig` while `fall_trig` and `clear_n` are both 1 is accepted. `pulse_o` is first seen high after the third rising clock edge that follows the input change.
- R3: A 0-to-1 change on `rise_trig` while `fall_trig` is 0 is not accepted and leaves `pulse_o` at 0.
- R4: A 1-to-0 change on `fall_trig` while `rise_trig` is 0 and `clear_n` is 1 is accepted, with the same latency as R2. The same change while `rise_trig` is 1 is not accepted.
- R5: An accepted trigger holds `pulse_o` high for exactly PW_CYCLES clock cycles, counted from the cycle in which the trigger is detected. PW_CYCLES must be at least 1.
- R6: An accepted trigger that arrives while `pulse_o` is high restarts timing, so `pulse_o` stays high for PW_CYCLES cycles after the last accepted trigger. A trigger that arrives after the pulse has ended starts a fresh pulse.
- R7: A low level on `clear_n` drives `pulse_o` to 0 after the same three-edge latency, even part-way through a pulse.
- R8: While `clear_n` is 0, trigger edges are ignored and are not remembered, so raising `clear_n` again does not start a pulse.
- R9: `pulse_n_o` is always the complement of `pulse_o`.
- R10: Asserting `rst` during a pulse returns the block to idle at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rise_trig | input | 1 | Asynchronous trigger, fires on its rising edge |
| fall_trig | input | 1 | Asynchronous trigger, fires on its falling edge |
| clear_n | input | 1 | Asynchronous clear, active low |
| pulse_o | output | 1 | One-shot pulse, high while timing |
| pulse_n_o | output | 1 | Complement of pulse_o |

## Verification
Single triggers on each input measure the exact start cycle and width. They show whether latency or counting is off by one. The same edges are then given with the other input at its blocking level. This separates the two qualification rules from plain edge detection.

Two patterns probe the restart rule. A second rising edge inside the pulse must stretch it. A second edge that lands just after the pulse ends must leave a one-cycle gap and then a fresh pulse. Together they tell restart apart from a simple OR of pulses.

Clear is tested in three ways: lowered mid-pulse, held low while edges arrive, and released while a trigger line is already high. This separates truncation, suppression and edge storage. A final pattern applies reset mid-pulse.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Synchronised view of the three control lines
    typedef struct packed {
        logic clr_n;
        logic fall;
        logic rise;
    } os_lines_t;

    // Levels the lines rest at when nothing happens
    localparam os_lines_t OS_IDLE_LINES = '{clr_n: 1'b1, fall: 1'b1, rise: 1'b0};

    typedef enum logic {
        OS_IDLE = 1'b0,
        OS_HOLD = 1'b1
    } os_state_t;

endpackage

// File: rtl/os_sync.sv
module os_sync #(
    parameter int          WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic s1;
        logic s2;
    } sync_pair_t;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        sync_pair_t stage_d, stage_q;

        always_comb begin
            stage_d    = stage_q;
            stage_d.s1 = din[g];
            stage_d.s2 = stage_q.s1;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '{s1: RST_VAL[g], s2: RST_VAL[g]};
            end else begin
                stage_q <= stage_d;
            end
        end

        assign dout[g] = stage_q.s2;
    end

endmodule

// File: rtl/os_trig_qual.sv
module os_trig_qual
    import oneshot_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  os_lines_t lines,
    output logic      fire
);

    typedef struct packed {
        logic rise;
        logic fall;
    } prev_t;

    prev_t prev_d, prev_q;
    logic  rise_edge;
    logic  fall_edge;

    // Previous samples are always updated, so an edge seen during clear is lost
    always_comb begin
        prev_d      = prev_q;
        prev_d.rise = lines.rise;
        prev_d.fall = lines.fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '{rise: OS_IDLE_LINES.rise, fall: OS_IDLE_LINES.fall};
        end else begin
            prev_q <= prev_d;
        end
    end

    always_comb begin
        rise_edge = lines.rise & ~prev_q.rise & lines.fall;
        fall_edge = ~lines.fall & prev_q.fall & ~lines.rise;
        fire      = lines.clr_n & (rise_edge | fall_edge);
    end

endmodule

// File: rtl/os_timer.sv
module os_timer
    import oneshot_pkg::*;
#(
    parameter int PW_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic clr_n_s,
    output logic active
);

    localparam int CW = (PW_CYCLES > 1) ? $clog2(PW_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(PW_CYCLES - 1);

    typedef struct packed {
        os_state_t     state;
        logic [CW-1:0] cnt;
    } timer_t;

    timer_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (fire) begin
            tm_d.state = OS_HOLD;
            tm_d.cnt   = LOAD;
        end else if (!clr_n_s) begin
            tm_d.state = OS_IDLE;
            tm_d.cnt   = '0;
        end else if (tm_q.state == OS_HOLD) begin
            if (tm_q.cnt == '0) begin
                tm_d.state = OS_IDLE;
            end else begin
                tm_d.cnt = tm_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tm_q <= '{state: OS_IDLE, cnt: '0};
        end else begin
            tm_q <= tm_d;
        end
    end

    assign active = (tm_q.state == OS_HOLD);

    // R2 / R4: an accepted trigger loads a full width
    assert_fire_loads_R2: assert property (@(posedge clk) disable iff (rst)
        fire |=> (active && tm_q.cnt == LOAD));

    // R7: clear without trigger ends timing
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
        (!clr_n_s && !fire) |=> !active);

    // R1: no pulse starts without a trigger
    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (!active && !fire) |=> !active);

    // R5: each running cycle counts down by one
    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        (active && tm_q.cnt != '0 && clr_n_s && !fire)
        |=> (active && tm_q.cnt == $past(tm_q.cnt) - 1'b1));

    // R5: the pulse ends after the last counted cycle
    assert_count_end_R5: assert property (@(posedge clk) disable iff (rst)
        (active && tm_q.cnt == '0 && !fire) |=> !active);

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
    import oneshot_pkg::*;
#(
    parameter int PW_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic rise_trig,
    input  logic fall_trig,
    input  logic clear_n,
    output logic pulse_o,
    output logic pulse_n_o
);

    localparam int NLINES = $bits(os_lines_t);

    os_lines_t raw_lines;
    os_lines_t sync_lines;
    logic      fire;
    logic      active;

    always_comb begin
        raw_lines.rise  = rise_trig;
        raw_lines.fall  = fall_trig;
        raw_lines.clr_n = clear_n;
    end

    os_sync #(
        .WIDTH   (NLINES),
        .RST_VAL (OS_IDLE_LINES)
    ) i_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    os_trig_qual i_qual (
        .clk   (clk),
        .rst   (rst),
        .lines (sync_lines),
        .fire  (fire)
    );

    os_timer #(
        .PW_CYCLES (PW_CYCLES)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .fire    (fire),
        .clr_n_s (sync_lines.clr_n),
        .active  (active)
    );

    assign pulse_o   = active;
    assign pulse_n_o = ~active;

    // R8: while the synchronised clear is low, no trigger is accepted
    assert_no_fire_in_clear_R8: assert property (@(posedge clk) disable iff (rst)
        !sync_lines.clr_n |-> !fire);

endmodule

// File: tb/test_retrig_oneshot.sv
module test_retrig_oneshot;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rise_trig = 1'b0;
    logic fall_trig = 1'b1;
    logic clear_n   = 1'b1;
    logic pulse_o;
    logic pulse_n_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    retrig_oneshot #(.PW_CYCLES(PW)) i_retrig_oneshot (
        .clk       (clk),
        .rst       (rst),
        .rise_trig (rise_trig),
        .fall_trig (fall_trig),
        .clear_n   (clear_n),
        .pulse_o   (pulse_o),
        .pulse_n_o (pulse_n_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Sample at negedges 1..total after the reference negedge; high expected in [lo1,hi1] or [lo2,hi2]
    task automatic watch(input string tag, input int lo1, input int hi1,
                         input int lo2, input int hi2, input int total);
        for (int i = 1; i <= total; i++) begin
            logic exp;
            @(negedge clk);
            exp = ((i >= lo1 && i <= hi1) || (i >= lo2 && i <= hi2));
            check($sformatf("%s cycle %0d", tag, i), pulse_o, exp);
            check($sformatf("R9 complement cycle %0d", i), pulse_n_o, ~exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset_idle();
        settle(1);
        check("R1 reset pulse_o", pulse_o, 1'b0);
        check("R1 reset pulse_n_o", pulse_n_o, 1'b1);
        watch("R1 idle", 1, 0, 1, 0, 6);
    endtask

    task automatic t_rise_fire();
        rise_trig = 1'b1;
        fork
            watch("R2 R5 rise width", 3, PW + 2, 1, 0, PW + 6);
            begin settle(2); rise_trig = 1'b0; end
        join
    endtask

    task automatic t_fall_fire();
        fall_trig = 1'b0;
        fork
            watch("R4 R5 fall width", 3, PW + 2, 1, 0, PW + 6);
            begin settle(2); fall_trig = 1'b1; end
        join
    endtask

    task automatic t_blocked_edges();
        clear_n = 1'b0;
        settle(4);
        fall_trig = 1'b0;
        settle(4);
        clear_n = 1'b1;
        watch("R8 release no fire", 1, 0, 1, 0, 6);
        rise_trig = 1'b1;
        watch("R3 rise blocked", 1, 0, 1, 0, 8);
        fall_trig = 1'b1;
        watch("R4 fall rising no fire", 1, 0, 1, 0, 6);
        fall_trig = 1'b0;
        watch("R4 fall blocked by rise", 1, 0, 1, 0, 8);
        rise_trig = 1'b0;
        settle(4);
        fall_trig = 1'b1;
        watch("R3 restore quiet", 1, 0, 1, 0, 6);
    endtask

    task automatic t_retrigger_stretch();
        rise_trig = 1'b1;
        fork
            watch("R6 stretch", 3, PW + 6, 1, 0, PW + 10);
            begin settle(2); rise_trig = 1'b0; settle(2); rise_trig = 1'b1;
                  settle(2); rise_trig = 1'b0; end
        join
    endtask

    task automatic t_retrigger_after_end();
        rise_trig = 1'b1;
        fork
            watch("R6 fresh after end", 3, PW + 2, PW + 4, 2 * PW + 3, 2 * PW + 6);
            begin settle(2); rise_trig = 1'b0; settle(PW - 1); rise_trig = 1'b1;
                  settle(2); rise_trig = 1'b0; end
        join
    endtask

    task automatic t_clear_truncate();
        rise_trig = 1'b1;
        fork
            watch("R7 truncate", 3, 6, 1, 0, 12);
            begin settle(2); rise_trig = 1'b0; settle(2); clear_n = 1'b0; end
        join
        rise_trig = 1'b1;
        watch("R8 rise during clear", 1, 0, 1, 0, 6);
        rise_trig = 1'b0;
        settle(2);
        fall_trig = 1'b0;
        watch("R8 fall during clear", 1, 0, 1, 0, 6);
        fall_trig = 1'b1;
        settle(2);
        rise_trig = 1'b1;
        settle(4);
        clear_n = 1'b1;
        watch("R8 release with rise high", 1, 0, 1, 0, 8);
        rise_trig = 1'b0;
        settle(4);
    endtask

    task automatic t_reset_mid_pulse();
        rise_trig = 1'b1;
        fork
            watch("R10 reset mid pulse", 3, 5, 1, 0, 12);
            begin settle(2); rise_trig = 1'b0; settle(3); rst = 1'b1;
                  settle(1); rst = 1'b0; end
        join
        watch("R10 idle after reset", 1, 0, 1, 0, 4);
    endtask

    initial begin
        settle(4);
        rst = 1'b0;
        t_reset_idle();
        t_rise_fire();
        settle(3);
        t_fall_fire();
        settle(3);
        t_blocked_edges();
        t_retrigger_stretch();
        settle(3);
        t_retrigger_after_end();
        settle(3);
        t_clear_truncate();
        t_reset_mid_pulse();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule